// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits in a PC host bridge and sorts every memory access that lands in the legacy window from 0xA0000 to 0xFFFFF. For each access it picks one of three actions: send it to system DRAM, pass it on to the expansion bus, or throw away a write. Accesses outside the window get a pass-through code, so the normal decode path can handle them.

Software programs the routing through a byte-wide configuration port. Seven attribute bytes hold 2-bit codes packed two per byte. One code covers the 64 KB top segment (0xF0000–0xFFFFF), and twelve codes cover the 16 KB option-ROM segments from 0xC0000 to 0xEFFFF. A separate window-control byte decides whether the video window (0xA0000–0xBFFFF) is backed by DRAM. That choice uses an "open" bit, or a second bit that only counts while the processor reports system-management mode through `smm_active`. A size byte records the installed memory in 8 MB units and is captured at reset.

The decode is purely combinational from the address, the write flag, `smm_active` and the stored bytes. A configuration write is registered on the clock edge, so it governs the access presented in the next cycle. The block has no state machine. Its only sequential state is the configuration byte storage.

Top module: `legacy_window_decoder`

## Requirements
- R1: `tgt_sel` uses the codes 0 = pass-through, 1 = DRAM, 2 = expansion bus, 3 = drop. Any address below 0xA0000 or at or above 0x100000 gives code 0.
- R2: After reset, attribute offsets 0x59–0x5F read 0x00 and the window-control offset 0x72 reads 0x02, so every access in the window goes to the bus.
- R3: After reset, offset 0x57 reads `mem_size_mb / 8`, saturated at 255.
- R4: Accesses in 0xF0000–0xFFFFF take their attribute from bits [5:4] of offset 0x59.
- R5: Option-ROM segment i (base 0xC0000 + i·0x4000, i = 0..11) takes its attribute from offset 0x5A + i/2: bits [1:0] when i is even, bits [5:4] when i is odd.
- R6: Attribute 3 sends both reads and writes to DRAM.
- R7: Attribute 1 sends reads to DRAM and drops writes. Code 3 never appears on a read.
- R8: Attributes 0 and 2 send both reads and writes to the bus.
- R9: In 0xA0000–0xBFFFF, when bit 6 of offset 0x72 is set, accesses go to DRAM whatever the state of `smm_active`. This window never produces the drop code.
- R10: In 0xA0000–0xBFFFF with bit 6 clear, accesses go to DRAM only while bit 3 of 0x72 is set and `smm_active` is high; otherwise they go to the bus. A change of `smm_active` takes effect in the same cycle.
- R11: A write to 0x57, 0x59–0x5F or 0x72 is stored on the clock edge, reads back on `cfg_rdata` in the next cycle, and governs the decode from the next cycle on.
- R12: Writes to any other offset are ignored, and such offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_size_mb | input | MEM_W | Installed memory in MB, sampled while in reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored byte at `cfg_addr` (combinational) |
| smm_active | input | 1 | Processor is in system-management mode |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read |
| tgt_sel | output | 2 | Target code (see R1) |

## Verification
The bench probes the segment edges where an off-by-one would show up:
- 0x9FFFF against 0xA0000, and 0xFFFFF against 0x100000 (R1). A wrong window bound would misroute or claim a neighbour's address.
- Odd/even segment pairs that share a byte (R5). A swapped nibble would send segment C4000 to the wrong target.
- Read against write under attribute 1 (R7). A decoder that ignored the write flag would store data into shadowed ROM.

It also toggles `smm_active` with only the SMM-qualified bit set, and then with the open bit set (R9, R10), so that a decoder which ignores either term routes the video window wrongly. A second reset with a large memory size checks the saturation of the size byte (R3), and also checks that earlier attribute writes are cleared. Writes to unrelated offsets (R12) must read back as zero.

// File: rtl/legwin_pkg.sv
package legwin_pkg;

    localparam logic [7:0] OFF_SIZE      = 8'h57;
    localparam logic [7:0] OFF_ATTR_BASE = 8'h59;
    localparam logic [7:0] OFF_SMRAM     = 8'h72;
    localparam logic [7:0] SMRAM_RST     = 8'h02;

    localparam int NUM_ATTR_BYTES = 7;
    localparam int NUM_ROM_SEG    = 12;
    localparam int SMRAM_OPEN_BIT = 6;
    localparam int SMRAM_SMM_BIT  = 3;

    typedef enum logic [1:0] {
        TGT_PASS = 2'd0,
        TGT_DRAM = 2'd1,
        TGT_BUS  = 2'd2,
        TGT_DROP = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_VGA  = 2'd1,
        RGN_ROM  = 2'd2,
        RGN_HIGH = 2'd3
    } rgn_e;

    typedef enum logic [1:0] {
        ATTR_OFF   = 2'd0,
        ATTR_RDONLY = 2'd1,
        ATTR_OFF2  = 2'd2,
        ATTR_RDWR  = 2'd3
    } attr_e;

endpackage

// File: rtl/legwin_cfg_regs.sv
module legwin_cfg_regs
    import legwin_pkg::*;
#(
    parameter int MEM_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [MEM_W-1:0]                 mem_size_mb,
    input  logic                             wr_en,
    input  logic [7:0]                       addr,
    input  logic [7:0]                       wdata,
    output logic [7:0]                       rdata,
    output logic [NUM_ATTR_BYTES-1:0][7:0]   attr_bytes,
    output logic [7:0]                       smram_byte
);

    localparam int IDX_W = $clog2(NUM_ATTR_BYTES);

    logic [7:0]       attr_q [NUM_ATTR_BYTES];
    logic [7:0]       smram_q;
    logic [7:0]       size_q;
    logic [MEM_W-1:0] size_units;
    logic [7:0]       size_rst;
    logic             in_attr;
    logic [IDX_W-1:0] attr_idx;
    logic [7:0]       attr_off;

    // memory size in 8 MB units, clipped to one byte
    assign size_units = mem_size_mb >> 3;
    assign size_rst   = (|size_units[MEM_W-1:8]) ? 8'hFF : size_units[7:0];

    assign attr_off = addr - OFF_ATTR_BASE;
    assign in_attr  = (addr >= OFF_ATTR_BASE) &&
                      (attr_off < 8'(NUM_ATTR_BYTES));
    assign attr_idx = attr_off[IDX_W-1:0];

    for (genvar b = 0; b < NUM_ATTR_BYTES; b++) begin : g_attr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                attr_q[b] <= 8'h00;
            end else if (wr_en && addr == 8'(OFF_ATTR_BASE + 8'(b))) begin
                attr_q[b] <= wdata;
            end
        end
        assign attr_bytes[b] = attr_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smram_q <= SMRAM_RST;
            size_q  <= size_rst;
        end else if (wr_en) begin
            if (addr == OFF_SMRAM) smram_q <= wdata;
            if (addr == OFF_SIZE)  size_q  <= wdata;
        end
    end

    assign smram_byte = smram_q;

    always_comb begin
        rdata = 8'h00;
        if (addr == OFF_SIZE) begin
            rdata = size_q;
        end else if (addr == OFF_SMRAM) begin
            rdata = smram_q;
        end else if (in_attr) begin
            rdata = attr_q[attr_idx];
        end
    end

endmodule

// File: rtl/legwin_seg_lookup.sv
module legwin_seg_lookup
    import legwin_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]               acc_addr,
    input  logic [NUM_ATTR_BYTES-1:0][7:0]  attr_bytes,
    output rgn_e                            region,
    output attr_e                           attr
);

    localparam int ROM_V_W = 2 * NUM_ROM_SEG;

    logic [ROM_V_W-1:0] rom_attr_v;
    logic [3:0]         seg_idx;
    logic               upper_zero;

    // segment s lives in byte 1 + s/2, low or high nibble by parity
    for (genvar s = 0; s < NUM_ROM_SEG; s++) begin : g_seg
        assign rom_attr_v[2*s +: 2] = attr_bytes[1 + s/2][4*(s%2) +: 2];
    end

    assign upper_zero = (acc_addr[ADDR_W-1:20] == '0);
    assign seg_idx    = acc_addr[17:14];

    always_comb begin
        region = RGN_NONE;
        if (upper_zero) begin
            unique case (acc_addr[19:16])
                4'hA, 4'hB:       region = RGN_VGA;
                4'hC, 4'hD, 4'hE: region = RGN_ROM;
                4'hF:             region = RGN_HIGH;
                default:          region = RGN_NONE;
            endcase
        end
    end

    always_comb begin
        attr = ATTR_OFF;
        unique case (region)
            RGN_HIGH: attr = attr_e'(attr_bytes[0][5:4]);
            RGN_ROM:  attr = attr_e'(rom_attr_v[{seg_idx, 1'b0} +: 2]);
            default:  attr = ATTR_OFF;
        endcase
    end

endmodule

// File: rtl/legwin_target_map.sv
module legwin_target_map
    import legwin_pkg::*;
(
    input  rgn_e        region,
    input  attr_e       attr,
    input  logic [7:0]  smram_byte,
    input  logic        smm_active,
    input  logic        acc_write,
    output tgt_e        tgt
);

    logic vga_to_dram;

    assign vga_to_dram = smram_byte[SMRAM_OPEN_BIT] ||
                         (smm_active && smram_byte[SMRAM_SMM_BIT]);

    always_comb begin
        tgt = TGT_PASS;
        unique case (region)
            RGN_NONE: tgt = TGT_PASS;
            RGN_VGA:  tgt = vga_to_dram ? TGT_DRAM : TGT_BUS;
            default: begin
                unique case (attr)
                    ATTR_RDWR:   tgt = TGT_DRAM;
                    ATTR_RDONLY: tgt = acc_write ? TGT_DROP : TGT_DRAM;
                    default:     tgt = TGT_BUS;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
    import legwin_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MEM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_W-1:0]  mem_size_mb,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              smm_active,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic [1:0]        tgt_sel
);

    logic [NUM_ATTR_BYTES-1:0][7:0] attr_bytes;
    logic [7:0]                     smram_q;
    rgn_e                           region;
    attr_e                          attr;
    tgt_e                           tgt;

    legwin_cfg_regs #(.MEM_W(MEM_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_size_mb(mem_size_mb),
        .wr_en      (cfg_wr_en),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .attr_bytes (attr_bytes),
        .smram_byte (smram_q)
    );

    legwin_seg_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .acc_addr  (acc_addr),
        .attr_bytes(attr_bytes),
        .region    (region),
        .attr      (attr)
    );

    legwin_target_map u_map (
        .region    (region),
        .attr      (attr),
        .smram_byte(smram_q),
        .smm_active(smm_active),
        .acc_write (acc_write),
        .tgt       (tgt)
    );

    assign tgt_sel = tgt;

endmodule

// File: rtl/legwin_checker.sv
module legwin_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic              smm_active,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic [1:0]        tgt_sel,
    input logic [7:0]        smram_byte
);

    logic in_window;
    logic in_video;
    logic stored_off;

    assign in_window  = (acc_addr >= ADDR_W'(32'hA0000)) &&
                        (acc_addr <= ADDR_W'(32'hFFFFF));
    assign in_video   = (acc_addr[ADDR_W-1:17] == (ADDR_W-17)'(5));
    assign stored_off = (cfg_addr == 8'h57) || (cfg_addr == 8'h72) ||
                        (cfg_addr >= 8'h59 && cfg_addr <= 8'h5F);

    a_r1_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |-> tgt_sel == 2'd0);

    a_r7_drop_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel == 2'd3 |-> acc_write);

    a_r9_video_open: assert property (@(posedge clk) disable iff (!rst_n)
        (in_video && smram_byte[6]) |-> tgt_sel == 2'd1);

    a_r10_video_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_video && !smram_byte[6] && !(smm_active && smram_byte[3]))
            |-> tgt_sel == 2'd2);

    a_r11_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && stored_off) |=>
            (cfg_addr != $past(cfg_addr) || cfg_rdata == $past(cfg_wdata)));

    a_r12_unstored_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !stored_off |-> cfg_rdata == 8'h00);

endmodule

bind legacy_window_decoder legwin_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .smm_active(smm_active),
    .acc_addr  (acc_addr),
    .acc_write (acc_write),
    .tgt_sel   (tgt_sel),
    .smram_byte(smram_q)
);

// File: tb/legacy_window_decoder_bench.sv
module legacy_window_decoder_bench;

    localparam int ADDR_W = 32;
    localparam int MEM_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MEM_W-1:0]  mem_size_mb = '0;
    logic              cfg_wr_en = 1'b0;
    logic [7:0]        cfg_addr = 8'h00;
    logic [7:0]        cfg_wdata = 8'h00;
    logic [7:0]        cfg_rdata;
    logic              smm_active = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              acc_write = 1'b0;
    logic [1:0]        tgt_sel;

    always #5 clk = ~clk;

    legacy_window_decoder #(.ADDR_W(ADDR_W), .MEM_W(MEM_W)) u_legacy_window_decoder (
        .clk(clk), .rst_n(rst_n), .mem_size_mb(mem_size_mb),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .smm_active(smm_active),
        .acc_addr(acc_addr), .acc_write(acc_write), .tgt_sel(tgt_sel)
    );

    typedef struct {
        bit         is_rd;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t      sb_q[$];
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    logic [7:0] shadow [256];

    function automatic bit is_stored(logic [7:0] off);
        return off == 8'h57 || off == 8'h72 || (off >= 8'h59 && off <= 8'h5F);
    endfunction

    function automatic logic [1:0] model_tgt(logic [31:0] a, bit wr, bit smm);
        logic [1:0] at;
        logic [7:0] b;
        int         i;
        if (a < 32'hA0000 || a > 32'hFFFFF) return 2'd0;
        if (a < 32'hC0000)
            return (shadow[8'h72][6] || (smm && shadow[8'h72][3])) ? 2'd1 : 2'd2;
        if (a >= 32'hF0000) begin
            at = shadow[8'h59][5:4];
        end else begin
            i  = int'((a - 32'hC0000) / 32'h4000);
            b  = shadow[8'h5A + i / 2];
            at = (i % 2 == 1) ? b[5:4] : b[1:0];
        end
        case (at)
            2'd3:    return 2'd1;
            2'd1:    return wr ? 2'd3 : 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    task automatic do_reset(input logic [MEM_W-1:0] mb);
        @(negedge clk);
        rst_n = 1'b0;
        mem_size_mb = mb;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 256; k++) shadow[k] = 8'h00;
        shadow[8'h72] = 8'h02;
        shadow[8'h57] = (mb / 8 > 255) ? 8'hFF : 8'(mb / 8);
        rst_n = 1'b1;
    endtask

    task automatic do_access(input logic [31:0] a, input bit wr, input bit smm,
                             input string req);
        item_t it;
        @(negedge clk);
        acc_addr = a;
        acc_write = wr;
        smm_active = smm;
        it.is_rd = 1'b0;
        it.exp = {6'b0, model_tgt(a, wr, smm)};
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic do_read(input logic [7:0] off, input string req);
        item_t it;
        @(negedge clk);
        cfg_addr = off;
        cfg_wr_en = 1'b0;
        it.is_rd = 1'b1;
        it.exp = shadow[off];
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic do_write(input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = off;
        cfg_wdata = d;
        cfg_wr_en = 1'b1;
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b0;
        if (is_stored(off)) shadow[off] = d;
    endtask

    // monitor: compare away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                act = it.is_rd ? cfg_rdata : {6'b0, tgt_sel};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(16'd1024);
        do_read(8'h72, "R2 smram reset");
        for (int o = 8'h59; o <= 8'h5F; o++) do_read(8'(o), "R2 attr reset");
        do_read(8'h57, "R3 size 1024MB");
        do_access(32'h000A0000, 1'b0, 1'b0, "R2 video to bus");
        do_access(32'h000C0000, 1'b1, 1'b0, "R2 rom to bus");
        do_access(32'h000FFFFF, 1'b0, 1'b0, "R2 high to bus");
        do_access(32'h00000000, 1'b0, 1'b0, "R1 low pass");
        do_access(32'h0009FFFF, 1'b1, 1'b0, "R1 below window");
        do_access(32'h00100000, 1'b0, 1'b0, "R1 above window");
        do_access(32'h800F0000, 1'b0, 1'b0, "R1 upper alias");

        // high segment
        do_write(8'h59, 8'h30);
        do_read(8'h59, "R11 readback 59");
        do_access(32'h000F0000, 1'b0, 1'b0, "R4 R6 high read");
        do_access(32'h000FFFFF, 1'b1, 1'b0, "R4 R6 high write");
        do_access(32'h000EFFFF, 1'b0, 1'b0, "R4 rom unaffected");
        do_write(8'h59, 8'h20);
        do_access(32'h000F8000, 1'b1, 1'b0, "R8 high attr2");
        do_write(8'h59, 8'h10);
        do_access(32'h000F8000, 1'b1, 1'b0, "R7 high write drop");
        do_access(32'h000F8000, 1'b0, 1'b0, "R7 high read dram");

        // option-ROM segments
        do_write(8'h5A, 8'h13);
        do_access(32'h000C0000, 1'b0, 1'b0, "R5 R6 seg0 read");
        do_access(32'h000C3FFF, 1'b1, 1'b0, "R5 R6 seg0 write");
        do_access(32'h000C4000, 1'b0, 1'b0, "R5 R7 seg1 read");
        do_access(32'h000C4000, 1'b1, 1'b0, "R5 R7 seg1 write");
        do_access(32'h000C8000, 1'b1, 1'b0, "R5 R8 seg2");
        do_write(8'h5D, 8'h30);
        do_access(32'h000D8000, 1'b0, 1'b0, "R5 R8 seg6");
        do_access(32'h000DC000, 1'b1, 1'b0, "R5 R6 seg7");
        do_write(8'h5F, 8'h21);
        do_access(32'h000E8000, 1'b1, 1'b0, "R5 R7 seg10 write");
        do_access(32'h000EBFFF, 1'b0, 1'b0, "R5 R7 seg10 read");
        do_access(32'h000EC000, 1'b0, 1'b0, "R5 R8 seg11");
        do_access(32'h000EC000, 1'b1, 1'b0, "R5 R8 seg11 write");

        // video window
        do_write(8'h72, 8'h08);
        do_read(8'h72, "R11 readback 72");
        do_access(32'h000A0000, 1'b0, 1'b0, "R10 no smm bus");
        do_access(32'h000BFFFF, 1'b1, 1'b1, "R10 smm dram");
        do_access(32'h000BFFFF, 1'b1, 1'b0, "R10 smm drop back to bus");
        do_write(8'h72, 8'h40);
        do_access(32'h000A0000, 1'b1, 1'b0, "R9 open no smm");
        do_access(32'h000B0000, 1'b0, 1'b1, "R9 open smm");
        do_write(8'h72, 8'h00);
        do_access(32'h000A0000, 1'b0, 1'b1, "R10 closed smm");

        // ignored offsets and writable size byte
        do_write(8'h60, 8'hA5);
        do_read(8'h60, "R12 offset 60");
        do_write(8'h58, 8'hFF);
        do_read(8'h58, "R12 offset 58");
        do_write(8'h57, 8'h44);
        do_read(8'h57, "R11 readback 57");

        // second reset: saturation and clearing
        do_reset(16'd4096);
        do_read(8'h57, "R3 size saturates");
        do_read(8'h5A, "R2 attr cleared");
        do_access(32'h000F0000, 1'b0, 1'b0, "R2 high back to bus");
        do_access(32'h000C4000, 1'b1, 1'b0, "R2 seg1 back to bus");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule